// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves data between peripherals and memory for up to four requesting devices. A processor first sets up the controller through a small byte-wide register port. For each channel it loads a 16-bit start address, a 16-bit transfer count and a transfer direction. It then enables the channels and chooses the arbitration scheme.

When an enabled channel raises its request, the controller asks the processor for the bus and waits for the grant. It then runs single transfers for the winning channel. Each transfer has one cycle with the memory address on the bus, followed by a strobe cycle. A low ready input stretches the strobe cycle. During the strobe cycle the controller drives the read and write strobes for the chosen direction and pulls that channel's acknowledge low.

The controller flags the final transfer of each block and pulses a marker on every 128th transfer. It gives up the bus when no enabled request remains.

Top module: `quad_dma_ctrl`

## Requirements
- R1: With the rotate bit clear, the controller serves the lowest-numbered channel that is both enabled and requesting. Channel 0 wins over all others.
- R2: With the rotate bit set, priority starts at the channel after the one served last. After a transfer on channel k, channel k+1 (mod 4) has top priority. The pointer starts at channel 3 after reset, so channel 0 is first.
- R3: An enabled request makes `hold_req` rise. Until `hold_ack` is seen high, `bus_en` stays low and every `dack_n` bit stays high.
- R4: Each transfer has an address cycle (`bus_en` high, all `dack_n` high), then a strobe cycle (`bus_en` high, exactly one `dack_n` bit low). The strobes in the strobe cycle follow the 2-bit direction code: 01 pulls `io_rd_n` and `mem_wr_n` low; 10 pulls `mem_rd_n` and `io_wr_n` low; 00 and 11 (verify) pull no strobe low.
- R5: A transfer completes at a rising edge of the strobe cycle where `ready` is high. The `mem_addr` shown for the next transfer is the previous one plus 1, wrapping from 0xFFFF to 0x0000.
- R6: A block of count value N makes N+1 transfers. `term_cnt` is high only during the last strobe cycle. After that transfer, the channel's enable bit (read back through the mode register) is clear.
- R7: `mark` is high during the strobe cycle of every 128th transfer, counted from the last write to that channel's count register.
- R8: While `ready` is low in a strobe cycle, the cycle repeats with `mem_addr`, `dack_n` and the strobes unchanged.
- R9: Register map, on `cpu_addr`:
  - With bit 3 clear, bits 2:1 pick the channel and bit 0 picks address (0) or count (1). A byte toggle alternates low then high byte on each access to these registers.
  - Address 8 is the mode register: bits 3:0 are the channel enables and bit 4 is rotate. Writing it also clears the byte toggle.
  - Address 9 holds the direction codes, two bits per channel, channel c at bits 2c+1:2c.
- R10: Requests from disabled channels are ignored. `hold_req` falls once the last transfer ends with no enabled request pending.
- R11: Reset clears every enable bit, the mode and direction registers, and leaves `hold_req` low, `bus_en` low and all strobes and acknowledges high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Register port select, active high |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (advances byte toggle) |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while selected and reading |
| dreq | input | 4 | Channel transfer requests |
| dack_n | output | 4 | Channel acknowledges, active low |
| hold_req | output | 1 | Bus request to processor |
| hold_ack | input | 1 | Bus grant from processor |
| ready | input | 1 | Low inserts wait states |
| bus_en | output | 1 | High while the controller drives the bus |
| mem_addr | output | 16 | Memory address of current transfer |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| term_cnt | output | 1 | Last transfer of the block |
| mark | output | 1 | Every 128th transfer |

## Verification
An enabled request seen at a rising edge puts `hold_req` high one cycle later. The address cycle follows the edge that sees `hold_ack`, and the strobe cycle comes one cycle after that. A transfer completes at the first edge of its strobe cycle that sees `ready` high.

The bench drives inputs on falling edges and samples outputs 6 ns after each rising edge. At that point both the design's state and the inputs for the coming edge are settled. A transfer is therefore counted in exactly the cycle it completes, and the acknowledge, address, strobes, `term_cnt` and `mark` are all compared in that same cycle.

Register reads are sampled combinationally within the access cycle. Status such as the cleared enables and the dropped `hold_req` is checked only after the scoreboard queue has drained.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
    localparam int NCH         = 4;
    localparam int CW          = $clog2(NCH);
    localparam int AW          = 16;
    localparam int MARK_PERIOD = 128;
    localparam int MW          = $clog2(MARK_PERIOD);
    localparam int RAW         = 4;
    localparam int DW          = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HOLD, ST_ADDR, ST_XFER, ST_NEXT
    } seq_state_t;

    typedef enum logic [1:0] {
        DIR_VERIFY   = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_CHECK    = 2'b11
    } xfer_dir_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic [MW-1:0] mcnt;
    } chan_state_t;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobe_t;

    function automatic strobe_t strobes_for(input xfer_dir_t d);
        strobe_t s;
        s = '1;
        case (d)
            DIR_TO_MEM:   begin s.io_rd_n  = 1'b0; s.mem_wr_n = 1'b0; end
            DIR_FROM_MEM: begin s.mem_rd_n = 1'b0; s.io_wr_n  = 1'b0; end
            default:      s = '1;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/qdma_arb.sv
module qdma_arb
    import qdma_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  logic           rotate,
    input  logic [CW-1:0]  last_ch,
    output logic           grant_valid,
    output logic [CW-1:0]  grant_ch
);
    always_comb begin
        grant_valid = 1'b0;
        grant_ch    = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [CW-1:0] idx;
            idx = rotate ? CW'(last_ch + CW'(1) + CW'(i)) : CW'(i);
            if (!grant_valid && req[idx]) begin
                grant_valid = 1'b1;
                grant_ch    = idx;
            end
        end
    end
endmodule

// File: rtl/qdma_regs.sv
module qdma_regs
    import qdma_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [RAW-1:0]            addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    input  logic                      upd,
    input  logic [CW-1:0]             upd_ch,
    output logic [NCH-1:0]            enable,
    output logic                      rotate,
    output logic [2*NCH-1:0]          dir_reg,
    output chan_state_t [NCH-1:0]     chans
);
    localparam logic [RAW-1:0] MODE_ADDR = RAW'(8);
    localparam logic [RAW-1:0] DIR_ADDR  = RAW'(9);

    logic          byte_hi;
    logic          is_chan;
    logic          is_cnt;
    logic [CW-1:0] ch_sel;

    assign is_chan = !addr[RAW-1];
    assign is_cnt  = addr[0];
    assign ch_sel  = addr[CW:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chans   <= '0;
            enable  <= '0;
            rotate  <= 1'b0;
            dir_reg <= '0;
            byte_hi <= 1'b0;
        end else begin
            if (upd) begin
                chans[upd_ch].addr <= chans[upd_ch].addr + AW'(1);
                chans[upd_ch].cnt  <= chans[upd_ch].cnt - AW'(1);
                chans[upd_ch].mcnt <= chans[upd_ch].mcnt + MW'(1);
                if (chans[upd_ch].cnt == '0)
                    enable[upd_ch] <= 1'b0;
            end
            if (wr_en) begin
                if (is_chan) begin
                    if (is_cnt) begin
                        if (byte_hi) chans[ch_sel].cnt[AW-1:DW] <= wdata;
                        else         chans[ch_sel].cnt[DW-1:0]  <= wdata;
                        chans[ch_sel].mcnt <= '0;
                    end else begin
                        if (byte_hi) chans[ch_sel].addr[AW-1:DW] <= wdata;
                        else         chans[ch_sel].addr[DW-1:0]  <= wdata;
                    end
                    byte_hi <= ~byte_hi;
                end else if (addr == MODE_ADDR) begin
                    enable  <= wdata[NCH-1:0];
                    rotate  <= wdata[NCH];
                    byte_hi <= 1'b0;
                end else if (addr == DIR_ADDR) begin
                    dir_reg <= wdata[2*NCH-1:0];
                end
            end else if (rd_en && is_chan) begin
                byte_hi <= ~byte_hi;
            end
        end
    end

    always_comb begin
        logic [AW-1:0] word;
        word  = is_cnt ? chans[ch_sel].cnt : chans[ch_sel].addr;
        rdata = '0;
        if (is_chan)               rdata = byte_hi ? word[AW-1:DW] : word[DW-1:0];
        else if (addr == MODE_ADDR) rdata = DW'({rotate, enable});
        else if (addr == DIR_ADDR)  rdata = DW'(dir_reg);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5: a finished transfer advances that channel's address by one
        assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
            (upd && !wr_en && upd_ch == CW'(g)) |=>
                (chans[g].addr == $past(chans[g].addr) + AW'(1)));
        // R6: the last transfer of a block disables its channel
        assert_tc_disable_R6: assert property (@(posedge clk) disable iff (rst)
            (upd && !wr_en && upd_ch == CW'(g) && chans[g].cnt == '0) |=> !enable[g]);
    end
endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
    import qdma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pending_valid,
    input  logic [CW-1:0]   grant_ch,
    input  logic            hold_ack,
    input  logic            ready,
    input  chan_state_t     cur,
    input  xfer_dir_t       cur_dir,
    output logic [CW-1:0]   act_ch,
    output logic [CW-1:0]   last_ch,
    output logic            upd,
    output logic            hold_req,
    output logic            bus_en,
    output logic [AW-1:0]   mem_addr,
    output logic [NCH-1:0]  dack_n,
    output strobe_t         strobes,
    output logic            term_cnt,
    output logic            mark
);
    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (pending_valid) state_nx = ST_HOLD;
            ST_HOLD: if (hold_ack) state_nx = pending_valid ? ST_ADDR : ST_IDLE;
            ST_ADDR: state_nx = ST_XFER;
            ST_XFER: if (ready) state_nx = ST_NEXT;
            ST_NEXT: state_nx = (hold_ack && pending_valid) ? ST_ADDR : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            act_ch  <= '0;
            last_ch <= CW'(NCH - 1);
        end else begin
            state <= state_nx;
            if (state_nx == ST_ADDR)
                act_ch <= grant_ch;
            if (upd)
                last_ch <= act_ch;
        end
    end

    logic in_xfer;
    assign in_xfer  = (state == ST_XFER);
    assign upd      = in_xfer && ready;
    assign hold_req = (state != ST_IDLE);
    assign bus_en   = (state == ST_ADDR) || in_xfer;
    assign mem_addr = bus_en ? cur.addr : '0;
    assign strobes  = in_xfer ? strobes_for(cur_dir) : '1;
    assign term_cnt = in_xfer && (cur.cnt == '0);
    assign mark     = in_xfer && (cur.mcnt == MW'(MARK_PERIOD - 1));

    always_comb begin
        dack_n = '1;
        if (in_xfer) dack_n[act_ch] = 1'b0;
    end

    // R3: the bus is driven only after a grant was seen
    assert_addr_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |-> $past(hold_ack));
    // R4: at most one acknowledge at a time
    assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));
    // R8: a wait state repeats the strobe cycle unchanged
    assert_wait_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && !ready) |=> (state == ST_XFER && $stable(mem_addr) && $stable(dack_n)));
    // R10: nothing pending after a transfer releases the bus
    assert_hold_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NEXT && !pending_valid) |=> !hold_req);
endmodule

// File: rtl/quad_dma_ctrl.sv
module quad_dma_ctrl
    import qdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_sel,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [3:0]  cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    input  logic [3:0]  dreq,
    output logic [3:0]  dack_n,
    output logic        hold_req,
    input  logic        hold_ack,
    input  logic        ready,
    output logic        bus_en,
    output logic [15:0] mem_addr,
    output logic        mem_rd_n,
    output logic        mem_wr_n,
    output logic        io_rd_n,
    output logic        io_wr_n,
    output logic        term_cnt,
    output logic        mark
);
    logic [DW-1:0]         rdata_raw;
    logic                  upd;
    logic [CW-1:0]         act_ch, last_ch, grant_ch;
    logic                  grant_valid;
    logic [NCH-1:0]        enable;
    logic                  rotate;
    logic [2*NCH-1:0]      dir_reg;
    chan_state_t [NCH-1:0] chans;
    strobe_t               strobes;
    xfer_dir_t             cur_dir;

    qdma_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cpu_sel && cpu_wr),
        .rd_en  (cpu_sel && cpu_rd),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .rdata  (rdata_raw),
        .upd    (upd),
        .upd_ch (act_ch),
        .enable (enable),
        .rotate (rotate),
        .dir_reg(dir_reg),
        .chans  (chans)
    );

    qdma_arb u_arb (
        .req        (enable & dreq),
        .rotate     (rotate),
        .last_ch    (last_ch),
        .grant_valid(grant_valid),
        .grant_ch   (grant_ch)
    );

    assign cur_dir = xfer_dir_t'(dir_reg[2*act_ch +: 2]);

    qdma_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .pending_valid(grant_valid),
        .grant_ch     (grant_ch),
        .hold_ack     (hold_ack),
        .ready        (ready),
        .cur          (chans[act_ch]),
        .cur_dir      (cur_dir),
        .act_ch       (act_ch),
        .last_ch      (last_ch),
        .upd          (upd),
        .hold_req     (hold_req),
        .bus_en       (bus_en),
        .mem_addr     (mem_addr),
        .dack_n       (dack_n),
        .strobes      (strobes),
        .term_cnt     (term_cnt),
        .mark         (mark)
    );

    assign cpu_rdata = (cpu_sel && cpu_rd) ? rdata_raw : '0;
    assign mem_rd_n  = strobes.mem_rd_n;
    assign mem_wr_n  = strobes.mem_wr_n;
    assign io_rd_n   = strobes.io_rd_n;
    assign io_wr_n   = strobes.io_wr_n;
endmodule

// File: tb/quad_dma_ctrl_bench.sv
module quad_dma_ctrl_bench;
    logic        clk = 0, rst = 1;
    logic        cpu_sel = 0, cpu_wr = 0, cpu_rd = 0;
    logic [3:0]  cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata;
    logic [3:0]  dreq = 0, dack_n;
    logic        hold_req, hold_ack = 0, ready = 1, bus_en;
    logic [15:0] mem_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, term_cnt, mark;

    int n_checks = 0, n_fail = 0;
    logic block_ack = 0;
    logic done = 0;

    typedef struct {
        int         ch;
        logic [15:0] a;
        logic [1:0]  dir;
        logic        tc;
        logic        mk;
    } exp_t;
    exp_t q[$];

    quad_dma_ctrl u_quad_dma_ctrl (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .dack_n(dack_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .ready(ready), .bus_en(bus_en), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .term_cnt(term_cnt), .mark(mark)
    );

    always #4 clk = ~clk;

    // bus grant responder
    always @(negedge clk) hold_ack <= hold_req && !block_ack;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 0; cpu_rd = 0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c);
        wr(4'(2*ch), a[7:0]);   wr(4'(2*ch), a[15:8]);
        wr(4'(2*ch+1), c[7:0]); wr(4'(2*ch+1), c[15:8]);
    endtask

    task automatic push(input int ch, input logic [15:0] a, input logic [1:0] d,
                        input logic tc, input logic mk);
        exp_t e;
        e.ch = ch; e.a = a; e.dir = d; e.tc = tc; e.mk = mk;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        dreq = 0;
    endtask

    function automatic logic [3:0] strobe_exp(input logic [1:0] d);
        case (d)
            2'b01:   return 4'b1001;
            2'b10:   return 4'b0110;
            default: return 4'b1111;
        endcase
    endfunction

    // monitor: sample 6 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #6;
            if (!rst && dack_n != 4'hF && ready) begin
                int ch;
                ch = 0;
                for (int i = 0; i < 4; i++) if (!dack_n[i]) ch = i;
                if (q.size() == 0) begin
                    check("R10 unexpected transfer", {28'd0, dack_n}, 32'hF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check("R1/R2 channel and R5 address", {ch[15:0], mem_addr}, {e.ch[15:0], e.a});
                    check("R4 strobes", {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
                          {28'd0, strobe_exp(e.dir)});
                    check("R6 term_cnt", {31'd0, term_cnt}, {31'd0, e.tc});
                    check("R7 mark", {31'd0, mark}, {31'd0, e.mk});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        check("R11 idle outputs", {hold_req, bus_en, dack_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
              {2'b00, 4'hF, 4'hF});
        rd(4'h8, d); check("R11 mode cleared", {24'd0, d}, 32'h0);

        // R9: byte toggle and its clear by a mode write
        wr(4'h7, 8'h34); wr(4'h7, 8'h12);
        rd(4'h7, d); check("R9 count low byte", {24'd0, d}, 32'h34);
        rd(4'h7, d); check("R9 count high byte", {24'd0, d}, 32'h12);
        wr(4'h6, 8'h78);
        wr(4'h8, 8'h00);
        wr(4'h6, 8'h9A); wr(4'h6, 8'hBC);
        rd(4'h6, d); check("R9 toggle cleared low", {24'd0, d}, 32'h9A);
        rd(4'h6, d); check("R9 toggle cleared high", {24'd0, d}, 32'hBC);
        wr(4'h9, 8'h5A);
        rd(4'h9, d); check("R9 direction readback", {24'd0, d}, 32'h5A);

        // R1, R5, R6, R3, R10: fixed priority, wrap, disabled channel ignored
        prog(0, 16'h1234, 16'd2);
        prog(1, 16'hFFFF, 16'd1);
        wr(4'h9, 8'h09);
        block_ack = 1;
        wr(4'h8, 8'h03);
        dreq = 4'b0111;
        repeat (5) @(negedge clk);
        check("R3 request without grant", {27'd0, hold_req, bus_en, dack_n}, {27'd0, 2'b10, 4'hF});
        push(0, 16'h1234, 2'b01, 0, 0);
        push(0, 16'h1235, 2'b01, 0, 0);
        push(0, 16'h1236, 2'b01, 1, 0);
        push(1, 16'hFFFF, 2'b10, 0, 0);
        push(1, 16'h0000, 2'b10, 1, 0);
        block_ack = 0;
        drain();
        check("R10 bus released", {31'd0, hold_req}, 32'h0);
        rd(4'h8, d); check("R6 enables cleared", {24'd0, d}, 32'h0);

        // R2: rotating priority
        prog(2, 16'h4000, 16'd1);
        prog(3, 16'h5000, 16'd1);
        wr(4'h9, 8'h90);
        push(2, 16'h4000, 2'b01, 0, 0);
        push(3, 16'h5000, 2'b10, 0, 0);
        push(2, 16'h4001, 2'b01, 1, 0);
        push(3, 16'h5001, 2'b10, 1, 0);
        wr(4'h8, 8'h1C);
        dreq = 4'b1100;
        drain();

        // R8: wait states
        prog(1, 16'h0100, 16'd0);
        wr(4'h9, 8'h08);
        push(1, 16'h0100, 2'b10, 1, 0);
        wr(4'h8, 8'h02);
        dreq = 4'b0010;
        while (dack_n[1]) @(negedge clk);
        ready = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 stretched cycle", {dack_n, mem_rd_n, io_wr_n, mem_addr},
                  {4'b1101, 2'b00, 16'h0100});
        end
        ready = 1;
        drain();

        // R7: mark on the 128th transfer, verify direction
        prog(0, 16'h8000, 16'd129);
        wr(4'h9, 8'h00);
        for (int k = 0; k < 130; k++)
            push(0, 16'(16'h8000 + k), 2'b00, k == 129, k == 127);
        wr(4'h8, 8'h01);
        dreq = 4'b0001;
        drain();

        // R11: reset disables all channels
        wr(4'h8, 8'h0F);
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        dreq = 4'hF;
        repeat (10) @(negedge clk);
        check("R11 no bus request after reset", {31'd0, hold_req}, 32'h0);
        rd(4'h8, d); check("R11 enables cleared by reset", {24'd0, d}, 32'h0);
        dreq = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule